// File: doc/BRIEF.md
# Clock Pulse Skipper

This block slows a clock domain without touching its clock source. It produces a per-cycle clock-enable that downstream logic uses to gate its clock. Some enable pulses are dropped, and the fraction dropped is the requested throttle depth. The depth comes from one of two inputs. The first is a direct percentage from 0 to 100. The second is a 2-bit level code that selects one of three fixed depths, or no throttling.

The dropped pulses are spread evenly across a window of `WINDOW` cycles, which is 100 by default. Each window uses a phase accumulator that is cleared when the window starts. A window at depth N therefore drops exactly N pulses and keeps them as far apart as the ratio allows.

The depth is sampled once, on the first cycle of each window, and held until that window ends. A setting that changes in the middle of a window never produces a partial-window burst. The block has no data stream: all of its pins are plain control signals. The gated clock cell and the arbitration that picks a setting sit outside the block.

Top module: `clk_pulse_skipper`

## Requirements
- R1: While `rst_n` is low, `clk_en` is 1. The first rising edge after reset is released is step 0 of a new window.
- R2: With `use_level` = 1, `level_in` selects the depth: 0 gives 0, 1 gives 50, 2 gives 75 and 3 gives 85 skipped pulses per 100-cycle window.
- R3: With `use_level` = 0, a `pct_in` value N from 0 to 100 drops exactly N enables in every window.
- R4: With `use_level` = 0, any `pct_in` above 100 is treated as 100.
- R5: At depth 0, `clk_en` is 1 on every cycle of the window.
- R6: At depth 100, `clk_en` is 0 on every cycle of the window.
- R7: For window step j (0 to 99) at depth N, a pulse is skipped when floor((j+1)·N/100) > floor(j·N/100). `clk_en` is registered, so the value for step j appears right after the rising edge of step j.
- R8: The inputs are sampled only on step 0 of a window. A change on any other step has no effect until the next window starts.
- R9: The input that `use_level` does not select has no effect on `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the throttled domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_level | input | 1 | 1 selects the level code, 0 selects the percentage |
| pct_in | input | $clog2(WINDOW+1) | Direct throttle depth in percent |
| level_in | input | 2 | Level code: 0 none, 1 low, 2 medium, 3 high |
| clk_en | output | 1 | Registered clock-enable; 0 marks a skipped pulse |

## Verification
The bench builds the block with its default parameters: a 100-cycle window and level depths of 50, 75 and 85.

With these values every percentage maps directly to a skip count per window. The 7-bit `pct_in` can carry 101 to 127, so the saturation rule is reachable.

Each step is compared against a reference model of the accumulator phase. This exposes skips that are misplaced or bunched, not only wrong totals. Settings are changed in the middle of a window to confirm they are held, and a reset is applied in the middle of a window to confirm that a new window starts.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } skip_level_e;
endpackage

// File: rtl/cps_depth_decode.sv
// Turns the selected request into a skip depth (pulses dropped per window).
module cps_depth_decode
  import cps_pkg::*;
#(
  parameter int WINDOW   = 100,
  parameter int LOW_PCT  = 50,
  parameter int MED_PCT  = 75,
  parameter int HIGH_PCT = 85,
  localparam int DEPTH_W = $clog2(WINDOW + 1)
) (
  input  logic               use_level,
  input  logic [DEPTH_W-1:0] pct,
  input  skip_level_e        level,
  output logic [DEPTH_W-1:0] depth
);
  localparam logic [DEPTH_W-1:0] WIN_D = DEPTH_W'(WINDOW);

  logic [DEPTH_W-1:0] lvl_depth;
  logic [DEPTH_W-1:0] pct_depth;

  always_comb begin
    unique case (level)
      LVL_NONE: lvl_depth = '0;
      LVL_LOW:  lvl_depth = DEPTH_W'(LOW_PCT);
      LVL_MED:  lvl_depth = DEPTH_W'(MED_PCT);
      default:  lvl_depth = DEPTH_W'(HIGH_PCT);
    endcase
  end

  // A percentage above the window size saturates to a full skip.
  assign pct_depth = (pct > WIN_D) ? WIN_D : pct;
  assign depth     = use_level ? lvl_depth : pct_depth;
endmodule

// File: rtl/cps_window_ctl.sv
// Tracks the position inside the window and holds the depth it sampled on step 0.
module cps_window_ctl #(
  parameter int WINDOW = 100,
  localparam int DEPTH_W = $clog2(WINDOW + 1),
  localparam int POS_W   = $clog2(WINDOW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] req_depth,
  output logic [POS_W-1:0]   pos,
  output logic               win_first,
  output logic [DEPTH_W-1:0] act_depth
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WINDOW - 1);

  logic [DEPTH_W-1:0] held_q;

  assign win_first = (pos == '0);
  assign act_depth = win_first ? req_depth : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      held_q <= '0;
    end else begin
      pos    <= (pos == LAST) ? '0 : pos + 1'b1;
      held_q <= act_depth;
    end
  end
endmodule

// File: rtl/cps_accum.sv
// Phase accumulator: adds the depth on each step and skips one pulse on every wrap.
module cps_accum #(
  parameter int WINDOW = 100,
  localparam int DEPTH_W = $clog2(WINDOW + 1),
  localparam int ACC_W   = DEPTH_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_first,
  input  logic [DEPTH_W-1:0] depth,
  output logic               clk_en
);
  localparam logic [ACC_W-1:0] WIN_A = ACC_W'(WINDOW);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_base;
  logic [ACC_W-1:0] sum;
  logic             skip;

  assign acc_base = win_first ? '0 : acc_q;
  assign sum      = acc_base + {1'b0, depth};
  assign skip     = (sum >= WIN_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      clk_en <= 1'b1;
    end else begin
      acc_q  <= skip ? (sum - WIN_A) : sum;
      clk_en <= !skip;
    end
  end
endmodule

// File: rtl/clk_pulse_skipper.sv
module clk_pulse_skipper
  import cps_pkg::*;
#(
  parameter int WINDOW   = 100,
  parameter int LOW_PCT  = 50,
  parameter int MED_PCT  = 75,
  parameter int HIGH_PCT = 85
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           use_level,
  input  logic [$clog2(WINDOW + 1)-1:0]  pct_in,
  input  logic [1:0]                     level_in,
  output logic                           clk_en
);
  localparam int DEPTH_W = $clog2(WINDOW + 1);
  localparam int POS_W   = $clog2(WINDOW);

  logic [DEPTH_W-1:0] req_depth;
  logic [DEPTH_W-1:0] act_depth;
  logic [POS_W-1:0]   win_pos;
  logic               win_first;

  cps_depth_decode #(
    .WINDOW(WINDOW), .LOW_PCT(LOW_PCT), .MED_PCT(MED_PCT), .HIGH_PCT(HIGH_PCT)
  ) u_decode (
    .use_level(use_level),
    .pct      (pct_in),
    .level    (skip_level_e'(level_in)),
    .depth    (req_depth)
  );

  cps_window_ctl #(.WINDOW(WINDOW)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_depth(req_depth),
    .pos      (win_pos),
    .win_first(win_first),
    .act_depth(act_depth)
  );

  cps_accum #(.WINDOW(WINDOW)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_first(win_first),
    .depth    (act_depth),
    .clk_en   (clk_en)
  );
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int WINDOW   = 100,
  parameter int LOW_PCT  = 50,
  parameter int MED_PCT  = 75,
  parameter int HIGH_PCT = 85,
  localparam int DEPTH_W = $clog2(WINDOW + 1),
  localparam int POS_W   = $clog2(WINDOW)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               use_level,
  input logic [DEPTH_W-1:0] pct_in,
  input logic [1:0]         level_in,
  input logic [POS_W-1:0]   pos,
  input logic [DEPTH_W-1:0] req_depth,
  input logic [DEPTH_W-1:0] act_depth,
  input logic               clk_en
);
  localparam logic [POS_W-1:0]   LAST  = POS_W'(WINDOW - 1);
  localparam logic [POS_W-1:0]   ONE   = POS_W'(1);
  localparam logic [DEPTH_W-1:0] WIN_D = DEPTH_W'(WINDOW);

  // Counts the skips seen at the output. Step j of a window appears while pos == j+1,
  // and the last step appears while pos == 0 of the following window.
  logic [DEPTH_W:0] seen_cnt;
  logic             wrapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cnt <= '0;
      wrapped  <= 1'b0;
    end else begin
      if (pos == LAST) wrapped <= 1'b1;
      if (pos != '0)
        seen_cnt <= ((pos == ONE) ? '0 : seen_cnt) + {{DEPTH_W{1'b0}}, !clk_en};
    end
  end

  p_reset_en_r1: assert property (@(posedge clk) !rst_n |-> clk_en);

  p_lvl_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_level && level_in == 2'd0) |-> req_depth == '0);
  p_lvl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_level && level_in == 2'd1) |-> req_depth == DEPTH_W'(LOW_PCT));
  p_lvl_med_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_level && level_in == 2'd2) |-> req_depth == DEPTH_W'(MED_PCT));
  p_lvl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_level && level_in == 2'd3) |-> req_depth == DEPTH_W'(HIGH_PCT));

  p_pct_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_level && pct_in <= WIN_D) |-> req_depth == pct_in);
  p_window_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0 && wrapped) |->
      (seen_cnt + {{DEPTH_W{1'b0}}, !clk_en}) == {1'b0, $past(act_depth)});

  p_pct_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_level && pct_in > WIN_D) |-> req_depth == WIN_D);

  p_zero_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_depth == '0 |=> clk_en);

  p_full_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_depth == WIN_D |=> !clk_en);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pos != '0 |-> act_depth == $past(act_depth));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pos == LAST |=> pos == '0);
endmodule

bind clk_pulse_skipper cps_checker #(
  .WINDOW(WINDOW), .LOW_PCT(LOW_PCT), .MED_PCT(MED_PCT), .HIGH_PCT(HIGH_PCT)
) u_cps_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .use_level(use_level),
  .pct_in   (pct_in),
  .level_in (level_in),
  .pos      (win_pos),
  .req_depth(req_depth),
  .act_depth(act_depth),
  .clk_en   (clk_en)
);

// File: tb/test_clk_pulse_skipper.sv
`timescale 1ns/1ps
module test_clk_pulse_skipper;
  localparam int W = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       use_level;
  logic [6:0] pct_in;
  logic [1:0] level_in;
  logic       clk_en;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int mpos    = 0;   // model window step
  int mdepth  = 0;   // model latched depth
  int wskips  = 0;   // model skips seen this window

  always #10 clk = ~clk;

  clk_pulse_skipper i_clk_pulse_skipper (
    .clk(clk), .rst_n(rst_n), .use_level(use_level),
    .pct_in(pct_in), .level_in(level_in), .clk_en(clk_en)
  );

  function automatic int want_depth(bit sel, int p, int l);
    if (sel) begin
      case (l)
        0: return 0;
        1: return 50;
        2: return 75;
        default: return 85;
      endcase
    end
    return (p > W) ? W : p;
  endfunction

  function automatic bit want_en(int j, int d);
    return !(((j + 1) * d) / W > (j * d) / W);
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    vectors++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (step %0d depth %0d)", tag, act, exp, mpos, mdepth);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
  task automatic step(bit sel, int p, int l, string tag);
    bit exp;
    use_level = sel;
    pct_in    = 7'(p);
    level_in  = 2'(l);
    if (mpos == 0) begin
      mdepth = want_depth(sel, p, l);
      wskips = 0;
    end
    exp = want_en(mpos, mdepth);
    @(posedge clk);
    @(negedge clk);
    check(clk_en == exp, tag, clk_en, exp);
    if (!clk_en) wskips++;
    mpos = (mpos + 1) % W;
    if (mpos == 0) check(wskips == mdepth, {tag, " window count"}, wskips, mdepth);
  endtask

  task automatic window(bit sel, int p, int l, string tag);
    for (int i = 0; i < W; i++) step(sel, p, l, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17_0C3E));
    rst_n = 1'b1; use_level = 1'b0; pct_in = '0; level_in = '0;
    #1 rst_n = 1'b0;
    // R1: enable held high while in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(clk_en == 1'b1, "R1 reset", clk_en, 1);
    end
    rst_n = 1'b1;
    mpos = 0;

    window(0, 0,   0, "R5 pct 0");
    window(0, 100, 0, "R6 pct 100");
    window(0, 1,   0, "R3 pct 1");
    window(0, 99,  0, "R3 pct 99");
    window(0, 37,  0, "R7 pct 37");
    window(0, 120, 0, "R4 pct 120");
    window(0, 127, 0, "R4 pct 127");
    window(1, 0, 0, "R2 level 0");
    window(1, 0, 1, "R2 level 1");
    window(1, 0, 2, "R2 level 2");
    window(1, 0, 3, "R2 level 3");

    // R8: change the setting halfway through a window; the model keeps the sampled depth
    for (int i = 0; i < W; i++) step(0, (i < 50) ? 20 : 90, 0, "R8 mid-window change");
    for (int i = 0; i < W; i++) step((i >= 1), 63, 3, "R8 mode flip after step 0");

    // R9: unselected input toggles randomly every cycle
    for (int i = 0; i < W; i++) step(1, int'($urandom_range(0, 127)), 2, "R9 pct ignored");
    for (int i = 0; i < W; i++) step(0, 45, int'($urandom_range(0, 3)), "R9 level ignored");

    // Random windows, with setting noise on steps after step 0
    for (int k = 0; k < 16; k++) begin
      bit s = 1'($urandom_range(0, 1));
      int p = int'($urandom_range(0, 127));
      int l = int'($urandom_range(0, 3));
      for (int i = 0; i < W; i++) begin
        if (i == 0) step(s, p, l, "R7 random window");
        else step(1'($urandom_range(0, 1)), int'($urandom_range(0, 127)),
                  int'($urandom_range(0, 3)), "R8 random noise");
      end
    end

    // R1: reset in the middle of a window restarts at step 0
    for (int i = 0; i < 40; i++) step(0, 33, 0, "R7 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(clk_en == 1'b1, "R1 mid-run reset", clk_en, 1);
    rst_n = 1'b1;
    mpos = 0;
    window(0, 33, 0, "R1 restart window");
    window(0, 71, 0, "R7 pct 71");

    finish_run();
  end
endmodule